// File: doc/BRIEF.md
# Exception Entry Sequencer

This block takes the processor core from its current mode into an exception mode. Five sources can ask for entry. Two are level requests from the interrupt controller: a normal interrupt and a fast interrupt, each gated by its own mask input. Three are single-cycle pulses: a memory abort from the memory system, and an undefined-instruction flag and a software-interrupt flag from the decoder. Pulse requests are held inside the block until they are serviced.

The block never cuts an instruction short. It acts only on the cycle in which the core strobes that an instruction has retired. On that edge it picks the winning source and records the retiring instruction's address plus four as the return address. In the following cycle it raises three strobes together:
- a mode-change strobe with the new mode code;
- a link-register write strobe with the return address, which goes into the new mode's private link register;
- a fetch redirect strobe with that source's vector-table address.

A fast-bank select output tells the register file to swap in the extra private registers that the fast interrupt mode owns.

The controller has three states. IDLE means nothing is pending. WAIT_RETIRE means a request is pending and the block waits for a retire. ENTER is the single cycle in which the strobes are driven. The transitions are:
- IDLE→WAIT_RETIRE when a request appears without a retire.
- IDLE→ENTER or WAIT_RETIRE→ENTER when a retire arrives while a request is pending.
- WAIT_RETIRE→IDLE when every level request has dropped and no pulse is held.
- ENTER→IDLE or ENTER→WAIT_RETIRE, depending on whether anything is still pending.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `mode` is 0 (user), `fast_bank` is 0 and `mode_wr`, `lr_wr` and `redir_vld` are all 0.
- R2: Entry happens only at a retire. `mode_wr`, `lr_wr` and `redir_vld` rise together in the cycle after the clock edge that sampled `retire`=1 with a request pending. They stay high for exactly one cycle. With no retire, a pending request produces no strobe.
- R3: When several requests are pending at one retire, the winner is chosen in this order: abort first, then fast interrupt, then interrupt, then undefined instruction, then software interrupt.
- R4: `redir_addr` equals VEC_BASE (default 0) plus an offset that depends on the source: undefined 0x04, software interrupt 0x08, abort 0x0C, interrupt 0x18, fast interrupt 0x1C.
- R5: `lr_data` equals the `cur_pc` value sampled with the retire, plus 4.
- R6: Each source sets its own `mode` code: fast interrupt 1, interrupt 2, software interrupt 3, abort 4, undefined 5. `mode` changes only in a cycle where `mode_wr` is 1.
- R7: While `irq_mask` or `fiq_mask` is 1, the matching level request is ignored. A level request that drops before a retire causes no entry.
- R8: Abort, undefined and software-interrupt pulses are held until they are serviced. A held request that loses arbitration is taken at a later retire.
- R9: `fast_bank` is 1 exactly while `mode` is the fast interrupt code 1.
- R10: A `retire` strobe that arrives during the entry cycle is ignored, even if a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 1 | Interrupt request, level |
| fiq_req | input | 1 | Fast interrupt request, level |
| irq_mask | input | 1 | Masks irq_req when 1 |
| fiq_mask | input | 1 | Masks fiq_req when 1 |
| abort_pls | input | 1 | Memory abort pulse |
| undef_pls | input | 1 | Undefined-instruction pulse from decode |
| swi_pls | input | 1 | Software-interrupt pulse from decode |
| retire | input | 1 | Current instruction retires this cycle |
| cur_pc | input | ADDR_W | Address of the retiring instruction |
| mode | output | 3 | Current processor mode code |
| mode_wr | output | 1 | Mode-change strobe |
| lr_wr | output | 1 | Banked link-register write strobe |
| lr_data | output | ADDR_W | Return address for the link register |
| redir_vld | output | 1 | Fetch redirect strobe |
| redir_addr | output | ADDR_W | Vector-table target |
| fast_bank | output | 1 | Select extra fast-mode register bank |

## Verification
A wrong controller state shows at the ports within one cycle. A controller stuck in ENTER keeps `redir_vld` high on the next cycle. A controller that never leaves WAIT_RETIRE drops the strobe that should follow a retire. A held pulse that is lost or never cleared shows up at the next retire, as either a missing entry or a spurious one carrying the wrong vector and mode. A wrong grant or mapping is visible in the same strobe cycle through `redir_addr` and `mode`.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NSRC = 5;

    // priority index: lower wins
    localparam int SRC_ABT = 0;
    localparam int SRC_FIQ = 1;
    localparam int SRC_IRQ = 2;
    localparam int SRC_UND = 3;
    localparam int SRC_SWI = 4;

    // sources that arrive as single-cycle pulses and must be held
    localparam logic [NSRC-1:0] PULSE_SRC = 5'b11001;

    typedef enum logic [2:0] {
        MODE_USER = 3'd0,
        MODE_FAST = 3'd1,
        MODE_INTR = 3'd2,
        MODE_SUPV = 3'd3,
        MODE_ABRT = 3'd4,
        MODE_UNDF = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_WAIT_RETIRE = 2'd1,
        ST_ENTER       = 2'd2
    } seq_state_e;
endpackage

// File: rtl/exc_req_capture.sv
module exc_req_capture
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw_req,
    input  logic [NSRC-1:0] gate_off,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);
    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_src
            if (PULSE_SRC[i]) begin : g_held
                logic held_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        held_q <= 1'b0;
                    else
                        held_q <= (held_q | raw_req[i]) & ~clr[i];
                end
                assign pend[i] = held_q | raw_req[i];
            end else begin : g_level
                assign pend[i] = raw_req[i] & ~gate_off[i];
            end
        end
    endgenerate
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_pkg::*;
#(
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  pend,
    output logic [NSRC-1:0]  grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any
);
    always_comb begin
        logic found;
        found     = 1'b0;
        grant     = '0;
        grant_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && !found) begin
                found     = 1'b1;
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
        any = found;
    end
endmodule

// File: rtl/exc_vector_map.sv
module exc_vector_map
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0,
    parameter int                IDX_W    = $clog2(NSRC)
) (
    input  logic [IDX_W-1:0]  src_idx,
    output mode_e             new_mode,
    output logic [ADDR_W-1:0] vec_addr
);
    logic [7:0] offs;

    always_comb begin
        unique case (src_idx)
            IDX_W'(SRC_ABT): begin new_mode = MODE_ABRT; offs = 8'h0C; end
            IDX_W'(SRC_FIQ): begin new_mode = MODE_FAST; offs = 8'h1C; end
            IDX_W'(SRC_IRQ): begin new_mode = MODE_INTR; offs = 8'h18; end
            IDX_W'(SRC_UND): begin new_mode = MODE_UNDF; offs = 8'h04; end
            IDX_W'(SRC_SWI): begin new_mode = MODE_SUPV; offs = 8'h08; end
            default:         begin new_mode = MODE_SUPV; offs = 8'h08; end
        endcase
    end

    assign vec_addr = VEC_BASE + ADDR_W'(offs);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0,
    parameter int                INSN_B   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              fiq_req,
    input  logic              irq_mask,
    input  logic              fiq_mask,
    input  logic              abort_pls,
    input  logic              undef_pls,
    input  logic              swi_pls,
    input  logic              retire,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic [2:0]        mode,
    output logic              mode_wr,
    output logic              lr_wr,
    output logic [ADDR_W-1:0] lr_data,
    output logic              redir_vld,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              fast_bank
);
    localparam int IDX_W = $clog2(NSRC);

    seq_state_e        state_q, state_d;
    logic [NSRC-1:0]   raw_req, gate_off, pend, grant, clr;
    logic [IDX_W-1:0]  grant_idx;
    logic              any_pend, take;
    mode_e             map_mode, mode_q;
    logic [ADDR_W-1:0] map_vec;

    always_comb begin
        raw_req          = '0;
        raw_req[SRC_ABT] = abort_pls;
        raw_req[SRC_FIQ] = fiq_req;
        raw_req[SRC_IRQ] = irq_req;
        raw_req[SRC_UND] = undef_pls;
        raw_req[SRC_SWI] = swi_pls;
        gate_off          = '0;
        gate_off[SRC_FIQ] = fiq_mask;
        gate_off[SRC_IRQ] = irq_mask;
    end

    assign take = retire && any_pend && (state_q != ST_ENTER);
    assign clr  = take ? grant : '0;

    exc_req_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_req  (raw_req),
        .gate_off (gate_off),
        .clr      (clr),
        .pend     (pend)
    );

    exc_prio_sel #(.IDX_W(IDX_W)) u_sel (
        .pend      (pend),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (any_pend)
    );

    exc_vector_map #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)) u_map (
        .src_idx  (grant_idx),
        .new_mode (map_mode),
        .vec_addr (map_vec)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (take) state_d = ST_ENTER;
                            else if (any_pend) state_d = ST_WAIT_RETIRE;
            ST_WAIT_RETIRE: if (take) state_d = ST_ENTER;
                            else if (!any_pend) state_d = ST_IDLE;
            ST_ENTER:       state_d = any_pend ? ST_WAIT_RETIRE : ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // registered outputs, loaded on the edge that enters ST_ENTER
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_USER;
            lr_data    <= '0;
            redir_addr <= '0;
        end else if (take) begin
            mode_q     <= map_mode;
            lr_data    <= cur_pc + ADDR_W'(INSN_B);
            redir_addr <= map_vec;
        end
    end

    assign mode      = mode_q;
    assign mode_wr   = (state_q == ST_ENTER);
    assign lr_wr     = (state_q == ST_ENTER);
    assign redir_vld = (state_q == ST_ENTER);
    assign fast_bank = (mode_q == MODE_FAST);
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int ADDR_W = 32,
    parameter int INSN_B = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              retire,
    input logic [ADDR_W-1:0] cur_pc,
    input logic [2:0]        mode,
    input logic              mode_wr,
    input logic              lr_wr,
    input logic [ADDR_W-1:0] lr_data,
    input logic              redir_vld,
    input logic [ADDR_W-1:0] redir_addr
);
    AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr == lr_wr) && (lr_wr == redir_vld)); // R2
    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |=> !redir_vld); // R10
    AST_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redir_vld) |-> $past(retire)); // R2
    AST_RETURN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lr_wr) |-> lr_data == $past(cur_pc) + ADDR_W'(INSN_B)); // R5
    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> redir_addr[1:0] == 2'b00); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> (mode_wr || $stable(mode))); // R6
    AST_NOT_USER: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |-> mode != 3'd0); // R6
endmodule

bind exc_entry_seq exc_entry_chk #(.ADDR_W(ADDR_W), .INSN_B(INSN_B)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire     (retire),
    .cur_pc     (cur_pc),
    .mode       (mode),
    .mode_wr    (mode_wr),
    .lr_wr      (lr_wr),
    .lr_data    (lr_data),
    .redir_vld  (redir_vld),
    .redir_addr (redir_addr)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    localparam int ADDR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_req = 0, fiq_req = 0, irq_mask = 0, fiq_mask = 0;
    logic abort_pls = 0, undef_pls = 0, swi_pls = 0, retire = 0;
    logic [ADDR_W-1:0] cur_pc = '0;
    logic [2:0] mode;
    logic mode_wr, lr_wr, redir_vld, fast_bank;
    logic [ADDR_W-1:0] lr_data, redir_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fiq_req(fiq_req),
        .irq_mask(irq_mask), .fiq_mask(fiq_mask), .abort_pls(abort_pls),
        .undef_pls(undef_pls), .swi_pls(swi_pls), .retire(retire),
        .cur_pc(cur_pc), .mode(mode), .mode_wr(mode_wr), .lr_wr(lr_wr),
        .lr_data(lr_data), .redir_vld(redir_vld), .redir_addr(redir_addr),
        .fast_bank(fast_bank)
    );

    // req bits: {abt, fiq, irq, und, swi}
    typedef struct packed {
        logic [4:0]  req;
        logic        imask;
        logic        fmask;
        logic        vld;
        logic [2:0]  md;
        logic [7:0]  vec;
        logic [31:0] pc;
    } row_t;

    localparam row_t TBL [12] = '{
        '{5'b00001, 1'b0, 1'b0, 1'b1, 3'd3, 8'h08, 32'h0000_1000}, // R4 swi
        '{5'b00010, 1'b0, 1'b0, 1'b1, 3'd5, 8'h04, 32'h0000_2004}, // R4 und
        '{5'b10000, 1'b0, 1'b0, 1'b1, 3'd4, 8'h0C, 32'h0000_3008}, // R4 abt
        '{5'b00100, 1'b0, 1'b0, 1'b1, 3'd2, 8'h18, 32'h0000_400C}, // R4 irq
        '{5'b01000, 1'b0, 1'b0, 1'b1, 3'd1, 8'h1C, 32'h0000_5010}, // R4 fiq
        '{5'b11111, 1'b0, 1'b0, 1'b1, 3'd4, 8'h0C, 32'h0000_6014}, // R3
        '{5'b01111, 1'b0, 1'b0, 1'b1, 3'd1, 8'h1C, 32'h0000_7018}, // R3
        '{5'b00111, 1'b0, 1'b0, 1'b1, 3'd2, 8'h18, 32'h0000_801C}, // R3
        '{5'b00011, 1'b0, 1'b0, 1'b1, 3'd5, 8'h04, 32'h0000_9020}, // R3
        '{5'b00100, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 32'h0000_A024}, // R7
        '{5'b01100, 1'b0, 1'b1, 1'b1, 3'd2, 8'h18, 32'h0000_B028}, // R7
        '{5'b01111, 1'b1, 1'b1, 1'b1, 3'd5, 8'h04, 32'h0000_C02C}  // R7
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {irq_req, fiq_req, irq_mask, fiq_mask, abort_pls, undef_pls, swi_pls, retire} = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    // applies retire at current negedge; samples at the negedge after the edge
    task automatic retire_at(input logic [31:0] pc);
        retire = 1;
        cur_pc = pc;
        @(negedge clk);
        retire = 0;
        {abort_pls, undef_pls, swi_pls} = '0;
    endtask

    task automatic expect_entry(input string req, input logic [2:0] md,
                                input logic [7:0] vec, input logic [31:0] pc);
        check(req, {61'd0, mode_wr, lr_wr, redir_vld}, 64'd7);
        check(req, 64'(mode), 64'(md));
        check(req, 64'(redir_addr), 64'(vec));
        check(req, 64'(lr_data), 64'(pc + 32'd4));
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", {60'd0, mode_wr, lr_wr, redir_vld, fast_bank}, 64'd0);
        check("R1", 64'(mode), 64'd0);

        // table walk, R3 R4 R5 R6 R7
        for (int k = 0; k < 12; k++) begin
            do_reset();
            {abort_pls, fiq_req, irq_req, undef_pls, swi_pls} = TBL[k].req;
            irq_mask = TBL[k].imask;
            fiq_mask = TBL[k].fmask;
            retire_at(TBL[k].pc);
            {irq_req, fiq_req} = '0;
            if (TBL[k].vld) begin
                expect_entry($sformatf("R3/R4/R5/R6 row %0d", k), TBL[k].md, TBL[k].vec, TBL[k].pc);
                check("R9 fast bank", 64'(fast_bank), 64'(TBL[k].md == 3'd1));
            end else begin
                check("R7 masked irq", 64'(redir_vld), 64'd0);
                check("R7 mode stays", 64'(mode), 64'd0);
            end
        end

        // R2: held request with no retire gives no strobe, then one-cycle strobe
        do_reset();
        swi_pls = 1;
        idle_cycle();
        swi_pls = 0;
        for (int c = 0; c < 3; c++) begin
            check("R2 no retire", 64'(redir_vld | mode_wr | lr_wr), 64'd0);
            idle_cycle();
        end
        retire_at(32'h100);
        expect_entry("R2 entry", 3'd3, 8'h08, 32'h100);
        idle_cycle();
        check("R2 one cycle", 64'(redir_vld), 64'd0);
        check("R6 mode held", 64'(mode), 64'd3);

        // R8: two pulses, loser taken at later retire
        do_reset();
        undef_pls = 1; swi_pls = 1;
        idle_cycle();
        {undef_pls, swi_pls} = '0;
        idle_cycle();
        retire_at(32'h200);
        expect_entry("R8 first", 3'd5, 8'h04, 32'h200);
        idle_cycle();
        retire_at(32'h300);
        expect_entry("R8 held swi", 3'd3, 8'h08, 32'h300);
        idle_cycle();
        retire_at(32'h400);
        check("R8 cleared", 64'(redir_vld), 64'd0);

        // R7: level dropped before retire
        do_reset();
        irq_req = 1;
        idle_cycle();
        irq_req = 0;
        idle_cycle();
        retire_at(32'h500);
        check("R7 dropped level", 64'(redir_vld), 64'd0);

        // R10: retire held through entry cycle ignored
        do_reset();
        undef_pls = 1; swi_pls = 1;
        retire = 1; cur_pc = 32'h600;
        @(negedge clk);
        {undef_pls, swi_pls} = '0;
        cur_pc = 32'h604;
        expect_entry("R10 entry", 3'd5, 8'h04, 32'h600);
        @(negedge clk);
        retire = 0;
        check("R10 ignored retire", 64'(redir_vld), 64'd0);
        retire_at(32'h700);
        expect_entry("R10 later", 3'd3, 8'h08, 32'h700);

        // R9: fast bank follows mode through fiq then irq
        do_reset();
        fiq_req = 1;
        retire_at(32'h800);
        fiq_req = 0;
        idle_cycle();
        check("R9 fiq bank on", 64'(fast_bank), 64'd1);
        irq_req = 1;
        retire_at(32'h900);
        irq_req = 0;
        check("R9 irq mode", 64'(mode), 64'd2);
        check("R9 fiq bank off", 64'(fast_bank), 64'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule